// File: doc/BRIEF.md
# VLAN Membership Table Access Engine

This block keeps a 4096-entry VLAN membership table on chip. A host on a 16-bit register bus reaches the table indirectly. It loads a VID and an entry word into two staging registers, then writes a command word to a command register. A read command copies the addressed entry into two result registers. A write command stores the staged entry at the staged VID. Each entry holds three fields: a six-port member mask, a six-port untag mask and a 3-bit filtering ID (0 to 7).

A second, independent lookup port serves the forwarding datapath. It takes a VID and returns that entry's member and untag masks one cycle later. When the table-enable bit is clear, the lookup port returns zeros.

After reset the block clears every entry, one per cycle. Until that sweep ends, the lookup port returns zeros and the block drops table commands.

Top module: `vtbl_engine`

## Requirements
- R1: After reset, the following all read zero: the staging registers (0x0185, 0x0186), the result registers (0x018B, 0x018C) and the control register (0x010F). The lookup outputs are also zero.
- R2: Staging word 0 (0x0185) keeps the VID in bits 11:0, and bits 15:12 read zero. Staging word 1 (0x0186) keeps the entry packed as member mask in bits 5:0, untag mask in bits 11:6 and filtering ID in bits 14:12. Bit 15 always reads zero.
- R3: Writing 0x0F01 to the command register (0x0180) stores staging word 1 into the entry addressed by staging word 0. The stored value is visible from the second clock edge after the command write.
- R4: Writing 0x0E01 to the command register loads the staged VID into 0x018B and that entry's packed word (same layout as R2) into 0x018C. The result registers are valid after the second clock edge after the command write, and they change at no other time.
- R5: Any other value written to the command register has no effect on the table or the result registers.
- R6: An accepted command keeps the engine busy for the next clock edge. A command written in that cycle is dropped. Staging writes are still taken in that cycle.
- R7: After reset the block clears the table, one entry per cycle, for 4096 cycles. Every entry then reads zero. Commands written during the clear are dropped.
- R8: Bit 0 of 0x010F is the table-enable flag. The other bits of that register read zero.
- R9: The lookup port presents the member and untag masks of the entry at `lk_vid`, registered one clock after the VID is applied.
- R10: The lookup outputs are zero whenever the table-enable flag is clear or the reset clear is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 16 | Register address for writes and reads |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational from register state |
| lk_vid | input | 12 | VID presented to the lookup port |
| lk_member | output | 6 | Member port mask of the looked-up entry |
| lk_untag | output | 6 | Untag port mask of the looked-up entry |

## Verification
Directed cases cover the following:
- The extreme VIDs 0 and 4095.
- All-ones and all-zero masks, which show whether any field leaks into a neighbour.
- Near-miss command words (0x0F00, 0x0E02), which show whether the full 16-bit code is decoded.
- Back-to-back commands in both orders (read then write, write then read), which separate "busy drops the second command" from "the second command overrides the first".
- A write issued during the reset clear, aimed at an entry the clear has already passed. A dropped command leaves that entry zero; an accepted one would leave it non-zero.

Random writes and reads then run over a small VID pool, so entries are overwritten often. Each read-back and lookup is compared with a bench model of the table.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
    localparam int BUS_W  = 16;
    localparam int PORT_N = 6;
    localparam int FID_W  = 3;
    localparam int ENT_W  = 2 * PORT_N + FID_W;

    localparam logic [BUS_W-1:0] ADR_CMD  = 16'h0180;
    localparam logic [BUS_W-1:0] ADR_STG0 = 16'h0185;
    localparam logic [BUS_W-1:0] ADR_STG1 = 16'h0186;
    localparam logic [BUS_W-1:0] ADR_RES0 = 16'h018B;
    localparam logic [BUS_W-1:0] ADR_RES1 = 16'h018C;
    localparam logic [BUS_W-1:0] ADR_CTL  = 16'h010F;

    localparam logic [BUS_W-1:0] OP_FETCH = 16'h0E01;
    localparam logic [BUS_W-1:0] OP_STORE = 16'h0F01;

    // packed so that the member mask sits in the low bits
    typedef struct packed {
        logic [FID_W-1:0]  fid;
        logic [PORT_N-1:0] untag;
        logic [PORT_N-1:0] member;
    } vent_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE
    } eng_st_e;
endpackage

// File: rtl/vtbl_regs.sv
module vtbl_regs
    import vtbl_pkg::*;
#(
    parameter int VID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_i,
    input  logic [BUS_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o,
    input  logic             clr_busy_i,
    output logic             tbl_en_o,
    output logic [VID_W-1:0] acc_vid_o,
    input  vent_t            acc_rdata_i,
    output logic             st_wr_en_o,
    output vent_t            st_wdata_o
);
    localparam int PAD_VID = BUS_W - VID_W;
    localparam int PAD_ENT = BUS_W - ENT_W;

    typedef struct packed {
        logic [VID_W-1:0] stg_vid;
        vent_t            stg_ent;
        logic [VID_W-1:0] res_vid;
        vent_t            res_ent;
        logic             en;
        eng_st_e          state;
        logic [VID_W-1:0] op_vid;
        vent_t            op_ent;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_FETCH: begin
                r_d.res_vid = r_q.op_vid;
                r_d.res_ent = acc_rdata_i;
                r_d.state   = ST_IDLE;
            end
            ST_STORE: r_d.state = ST_IDLE;
            default:  ;
        endcase
        if (bus_wr_i) begin
            unique case (bus_addr_i)
                ADR_STG0: r_d.stg_vid = bus_wdata_i[VID_W-1:0];
                ADR_STG1: r_d.stg_ent = vent_t'(bus_wdata_i[ENT_W-1:0]);
                ADR_CTL:  r_d.en      = bus_wdata_i[0];
                ADR_CMD: begin
                    if (r_q.state == ST_IDLE && !clr_busy_i) begin
                        if (bus_wdata_i == OP_FETCH) begin
                            r_d.state  = ST_FETCH;
                            r_d.op_vid = r_q.stg_vid;
                        end else if (bus_wdata_i == OP_STORE) begin
                            r_d.state  = ST_STORE;
                            r_d.op_vid = r_q.stg_vid;
                            r_d.op_ent = r_q.stg_ent;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (bus_addr_i)
            ADR_STG0: bus_rdata_o = {{PAD_VID{1'b0}}, r_q.stg_vid};
            ADR_STG1: bus_rdata_o = {{PAD_ENT{1'b0}}, r_q.stg_ent};
            ADR_RES0: bus_rdata_o = {{PAD_VID{1'b0}}, r_q.res_vid};
            ADR_RES1: bus_rdata_o = {{PAD_ENT{1'b0}}, r_q.res_ent};
            ADR_CTL:  bus_rdata_o = {{(BUS_W-1){1'b0}}, r_q.en};
            default:  bus_rdata_o = '0;
        endcase
    end

    assign tbl_en_o   = r_q.en;
    assign acc_vid_o  = r_q.op_vid;
    assign st_wr_en_o = (r_q.state == ST_STORE);
    assign st_wdata_o = r_q.op_ent;

    // R6: a busy engine always returns to idle on the next edge
    assert_busy_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |=> (r_q.state == ST_IDLE));

    // R4: result registers move only on the edge that completes a fetch
    assert_result_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_FETCH) |=> ($stable(r_q.res_vid) && $stable(r_q.res_ent)));

    // R2: packed entry words never show bit 15
    assert_top_bit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == ADR_STG1 || bus_addr_i == ADR_RES1) |-> !bus_rdata_o[BUS_W-1]);

    // R8: a control write sets the enable flag from data bit 0
    assert_enable_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADR_CTL) |=> (tbl_en_o == $past(bus_wdata_i[0])));
endmodule

// File: rtl/vtbl_store.sv
module vtbl_store
    import vtbl_pkg::*;
#(
    parameter int VID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [VID_W-1:0] wr_vid_i,
    input  vent_t            wr_data_i,
    input  logic [VID_W-1:0] rd_a_vid_i,
    output vent_t            rd_a_o,
    input  logic [VID_W-1:0] rd_b_vid_i,
    output vent_t            rd_b_o,
    output logic             clr_busy_o
);
    localparam int DEPTH = 1 << VID_W;
    localparam logic [VID_W-1:0] LAST = VID_W'(DEPTH - 1);

    typedef struct packed {
        logic [VID_W-1:0] cnt;
        logic             busy;
    } clr_t;

    clr_t c_d, c_q;
    vent_t mem [DEPTH];

    always_comb begin
        c_d = c_q;
        if (c_q.busy) begin
            c_d.cnt = c_q.cnt + 1'b1;
            if (c_q.cnt == LAST) begin
                c_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{cnt: '0, busy: 1'b1};
        end else begin
            c_q <= c_d;
        end
    end

    always_ff @(posedge clk) begin
        if (c_q.busy) begin
            mem[c_q.cnt] <= '0;
        end else if (wr_en_i) begin
            mem[wr_vid_i] <= wr_data_i;
        end
    end

    assign rd_a_o     = mem[rd_a_vid_i];
    assign rd_b_o     = mem[rd_b_vid_i];
    assign clr_busy_o = c_q.busy;

    // R7: the command engine never stores while the clear sweep runs
    assert_no_store_in_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |-> !wr_en_i);
endmodule

// File: rtl/vtbl_lookup.sv
module vtbl_lookup
    import vtbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_busy_i,
    input  logic [PORT_N-1:0] member_i,
    input  logic [PORT_N-1:0] untag_i,
    output logic [PORT_N-1:0] member_o,
    output logic [PORT_N-1:0] untag_o
);
    typedef struct packed {
        logic [PORT_N-1:0] member;
        logic [PORT_N-1:0] untag;
    } lk_t;

    lk_t l_d, l_q;

    always_comb begin
        l_d = '0;
        if (en_i && !clr_busy_i) begin
            l_d.member = member_i;
            l_d.untag  = untag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign member_o = l_q.member;
    assign untag_o  = l_q.untag;

    // R10: a clear enable flag yields zero masks on the next cycle
    assert_off_gives_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || clr_busy_i) |=> (member_o == '0 && untag_o == '0));
endmodule

// File: rtl/vtbl_engine.sv
module vtbl_engine
    import vtbl_pkg::*;
#(
    parameter int VID_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [VID_W-1:0]  lk_vid,
    output logic [PORT_N-1:0] lk_member,
    output logic [PORT_N-1:0] lk_untag
);
    logic             clr_busy;
    logic             tbl_en;
    logic [VID_W-1:0] acc_vid;
    vent_t            acc_rdata;
    logic             st_wr_en;
    vent_t            st_wdata;
    vent_t            lk_ent;

    vtbl_regs #(.VID_W(VID_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .clr_busy_i  (clr_busy),
        .tbl_en_o    (tbl_en),
        .acc_vid_o   (acc_vid),
        .acc_rdata_i (acc_rdata),
        .st_wr_en_o  (st_wr_en),
        .st_wdata_o  (st_wdata)
    );

    vtbl_store #(.VID_W(VID_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (st_wr_en),
        .wr_vid_i   (acc_vid),
        .wr_data_i  (st_wdata),
        .rd_a_vid_i (acc_vid),
        .rd_a_o     (acc_rdata),
        .rd_b_vid_i (lk_vid),
        .rd_b_o     (lk_ent),
        .clr_busy_o (clr_busy)
    );

    vtbl_lookup u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (tbl_en),
        .clr_busy_i (clr_busy),
        .member_i   (lk_ent.member),
        .untag_i    (lk_ent.untag),
        .member_o   (lk_member),
        .untag_o    (lk_untag)
    );
endmodule

// File: tb/tb_vtbl_engine.sv
module tb_vtbl_engine;
    localparam logic [15:0] A_CMD  = 16'h0180;
    localparam logic [15:0] A_STG0 = 16'h0185;
    localparam logic [15:0] A_STG1 = 16'h0186;
    localparam logic [15:0] A_RES0 = 16'h018B;
    localparam logic [15:0] A_RES1 = 16'h018C;
    localparam logic [15:0] A_CTL  = 16'h010F;
    localparam logic [15:0] C_RD   = 16'h0E01;
    localparam logic [15:0] C_WR   = 16'h0F01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] lk_vid = '0;
    logic [5:0]  lk_member;
    logic [5:0]  lk_untag;

    int errs = 0;
    int checks = 0;
    logic [14:0] model [4096];

    always #10 clk = ~clk;

    vtbl_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lk_vid    (lk_vid),
        .lk_member (lk_member),
        .lk_untag  (lk_untag)
    );

    function automatic logic [15:0] pack(logic [5:0] m, logic [5:0] u, logic [2:0] f);
        return {1'b0, f, u, m};
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr2(logic [15:0] a0, logic [15:0] d0, logic [15:0] a1, logic [15:0] d1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a0; bus_wdata = d0;
        @(negedge clk);
        bus_addr = a1; bus_wdata = d1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic store(logic [11:0] v, logic [15:0] e);
        wr(A_STG0, {4'h0, v});
        wr(A_STG1, e);
        wr(A_CMD, C_WR);
        @(negedge clk);
    endtask

    task automatic fetch(logic [11:0] v, output logic [15:0] r0, output logic [15:0] r1);
        wr(A_STG0, {4'h0, v});
        wr(A_CMD, C_RD);
        @(negedge clk);
        rd(A_RES0, r0);
        rd(A_RES1, r1);
    endtask

    task automatic look(logic [11:0] v, output logic [15:0] lm, output logic [15:0] lu);
        @(negedge clk);
        lk_vid = v;
        @(negedge clk);
        lm = {10'h0, lk_member};
        lu = {10'h0, lk_untag};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] r0, r1, lm, lu, e;
        logic [11:0] v;
        void'($urandom(32'd7));
        foreach (model[i]) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STG0, r0); chk("R1 stg0", r0, 16'h0);
        rd(A_STG1, r0); chk("R1 stg1", r0, 16'h0);
        rd(A_RES0, r0); chk("R1 res0", r0, 16'h0);
        rd(A_RES1, r0); chk("R1 res1", r0, 16'h0);
        rd(A_CTL, r0);  chk("R1 ctl", r0, 16'h0);
        chk("R1 lookup", {4'h0, lk_member, lk_untag}, 16'h0);

        // R7: store during the clear sweep, to an entry already cleared
        repeat (20) @(negedge clk);
        store(12'd5, pack(6'h2A, 6'h15, 3'd3));
        wr(A_CTL, 16'h0001);
        // R10: lookup gated while clear runs
        look(12'd5, lm, lu);
        chk("R10 clear member", lm, 16'h0);
        repeat (4100) @(negedge clk);
        fetch(12'd5, r0, r1);
        chk("R7 res0", r0, 16'h0005);
        chk("R7 dropped store", r1, 16'h0);
        fetch(12'd4095, r0, r1);
        chk("R7 last entry", r1, 16'h0);

        // R2 staging layout
        wr(A_STG0, 16'hFABC); rd(A_STG0, r0); chk("R2 stg0", r0, 16'h0ABC);
        wr(A_STG1, 16'hFFFF); rd(A_STG1, r0); chk("R2 stg1", r0, 16'h7FFF);

        // R3 / R4 directed at the extreme VIDs
        store(12'hFFF, pack(6'h3F, 6'h00, 3'd7)); model[4095] = 15'h703F;
        fetch(12'hFFF, r0, r1);
        chk("R4 res0 max vid", r0, 16'h0FFF);
        chk("R3 max vid entry", r1, 16'h703F);
        store(12'h000, pack(6'h00, 6'h3F, 3'd0)); model[0] = 15'h0FC0;
        fetch(12'h000, r0, r1);
        chk("R4 res0 zero vid", r0, 16'h0000);
        chk("R3 zero vid entry", r1, 16'h0FC0);

        // R9 lookup
        look(12'hFFF, lm, lu);
        chk("R9 member", lm, 16'h003F); chk("R9 untag", lu, 16'h0000);
        look(12'h000, lm, lu);
        chk("R9 untag zero vid", lu, 16'h003F);

        // R8 / R10 enable flag
        wr(A_CTL, 16'hFFFE); rd(A_CTL, r0); chk("R8 ctl", r0, 16'h0);
        look(12'hFFF, lm, lu); chk("R10 disabled", lm, 16'h0);
        wr(A_CTL, 16'h0001); rd(A_CTL, r0); chk("R8 ctl set", r0, 16'h0001);

        // R5 near-miss command words
        wr(A_STG0, 16'h0FFF); wr(A_STG1, 16'h1111);
        wr(A_CMD, 16'h0F00); @(negedge clk);
        wr(A_STG0, 16'h0123);
        wr(A_CMD, 16'h0E02); @(negedge clk);
        rd(A_RES0, r0); chk("R5 res unchanged", r0, 16'h0000);
        fetch(12'hFFF, r0, r1); chk("R5 entry unchanged", r1, 16'h703F);

        // R6 fetch then store back to back: store dropped
        store(12'h020, pack(6'h01, 6'h02, 3'd1)); model[32] = 15'h1081;
        wr(A_STG1, 16'h7FFF);
        wr2(A_CMD, C_RD, A_CMD, C_WR); @(negedge clk);
        rd(A_RES1, r0); chk("R6 fetch taken", r0, 16'h1081);
        fetch(12'h020, r0, r1); chk("R6 store dropped", r1, 16'h1081);
        // R6 store then fetch back to back: fetch dropped
        wr(A_STG0, 16'h0021); wr(A_STG1, 16'h2345);
        wr2(A_CMD, C_WR, A_CMD, C_RD); @(negedge clk);
        rd(A_RES0, r0); chk("R6 fetch dropped", r0, 16'h0020);
        model[33] = 15'h2345;
        fetch(12'h021, r0, r1); chk("R6 store taken", r1, 16'h2345);

        // random mix, R3 R4 R9 against model
        for (int n = 0; n < 150; n++) begin
            v = ($urandom_range(0, 3) == 0) ? 12'(4095 - $urandom_range(0, 3))
                                            : 12'($urandom_range(0, 31));
            e = pack(6'($urandom()), 6'($urandom()), 3'($urandom()));
            store(v, e);
            model[v] = e[14:0];
            v = ($urandom_range(0, 1) == 0) ? v : 12'($urandom_range(0, 31));
            fetch(v, r0, r1);
            chk("R4 rand vid", r0, {4'h0, v});
            chk("R3 rand entry", r1, {1'b0, model[v]});
            look(v, lm, lu);
            chk("R9 rand member", lm, {10'h0, model[v][5:0]});
            chk("R9 rand untag", lu, {10'h0, model[v][11:6]});
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule